// File: doc/BRIEF.md
# Monitor-Data Freeze Controller

This block drives one freeze level that tells downstream cards to stop writing their circular monitoring buffers, so that software can read the captured history. It receives two request lines from each of several crate channels, a level-1 accept strobe and a "collect status" qualifier. Everything is sampled on the fast reference clock, but only on the cycle that follows a rising edge of the slower bunch-crossing clock. That slow clock is a level whose transitions line up with fast-clock edges.

Three things can start a freeze. The first is a self-trigger from any crate. The second is an armed "next accept" trigger. The third is an armed "next accept with qualifier" trigger. A dedicated stop line from a third crate ends the freeze. Once set, the freeze holds until it is stopped, whatever set it. The input capture, the arm flags and the freeze register all advance only on a slow-clock tick, so the freeze output changes only just after a rising edge of the slow clock.

Top module: `frz_ctrl`

## Requirements
- R1: While reset is asserted, and after it is released with idle inputs, `freeze_o` is 0.
- R2: `req_line0[c]` high at a slow tick for any crate c in 0..3 sets `freeze_o` to 1. The output rises at the next slow tick after the one that captured the request.
- R3: Both request lines of channel 4, `req_line0[4]` and `req_line1[4]`, have no effect on `freeze_o` or on arming.
- R4: A rising `req_line1[0]` arms the accept trigger. The next captured `l1_accept` then sets `freeze_o`, whatever the value of `collect_status`.
- R5: A rising `req_line1[1]` arms the qualified trigger. It fires only on a captured `l1_accept` together with `collect_status`. An accept alone or a qualifier alone does not fire it.
- R6: Once set, `freeze_o` stays 1 until a stop is requested.
- R7: `req_line1[2]` is the stop line. A captured stop forces `freeze_o` to 0 even when a start condition is captured in the same slow cycle.
- R8: An arm flag clears when its trigger fires. A later accept does not set the freeze again without re-arming.
- R9: A stop also clears both arm flags.
- R10: Arming needs a 0-to-1 transition of the arm line between captures. Holding the line high does not re-arm after a fire or a stop.
- R11: `req_line1[3]` has no effect.
- R12: `freeze_o` changes only on the fast-clock edge that follows a rising edge of `bx_clk`. Inputs are captured on that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bx_clk | input | 1 | Slow bunch-crossing clock level, sampled by `clk` |
| req_line0 | input | NUM_CH (5) | Self-trigger line per channel |
| req_line1 | input | NUM_CH (5) | Control line per channel: 0 arm accept, 1 arm qualified, 2 stop |
| l1_accept | input | 1 | Level-1 accept for this sector |
| collect_status | input | 1 | Qualifier valid together with `l1_accept` |
| freeze_o | output | 1 | Freeze level to the downstream cards |

## Verification
The inputs are held for one slow period at a time, and a behavioural model in the bench tracks the freeze level on every fast cycle. The self-trigger is tried on each crate in turn. This separates a correct OR over crates 0..3 from a decode that includes channel 4 or misses a crate. The accept trigger is tried with and without the qualifier, and the qualified trigger is tried with accept only, qualifier only and both together, which tells the two arming paths apart. Held arm lines, a stop captured together with a start, and accepts that arrive after a fire or after a stop expose edge-versus-level arming and the clearing priority. Checks made in the middle of a slow period catch any output that moves off the tick.

// File: rtl/frz_pkg.sv
package frz_pkg;
  localparam int NUM_CRATE     = 4;
  localparam int IDX_ARM_ACC   = 0;
  localparam int IDX_ARM_QUAL  = 1;
  localparam int IDX_STOP      = 2;
  localparam int NUM_ARM       = 2;

  typedef struct packed {
    logic [NUM_CRATE-1:0] self_trig;
    logic [NUM_CRATE-1:0] ctl;
    logic                 accept;
    logic                 qual;
  } samp_t;
endpackage

// File: rtl/frz_rst_sync.sv
module frz_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = chain_q[STAGES-1];
endmodule

// File: rtl/frz_tick_gen.sv
module frz_tick_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic bx_clk,
  output logic tick
);
  logic bx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bx_q <= 1'b0;
    else        bx_q <= bx_clk;
  end

  assign tick = bx_clk & ~bx_q;
endmodule

// File: rtl/frz_sampler.sv
module frz_sampler
  import frz_pkg::*;
#(
  parameter int NUM_CH = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [NUM_CH-1:0] line0,
  input  logic [NUM_CH-1:0] line1,
  input  logic              accept,
  input  logic              qual,
  output samp_t             samp_q,
  output logic [NUM_CRATE-1:0] ctl_prev_q
);
  samp_t samp_d;
  logic [NUM_CRATE-1:0] ctl_prev_d;

  always_comb begin
    samp_d     = samp_q;
    ctl_prev_d = ctl_prev_q;
    if (tick) begin
      ctl_prev_d       = samp_q.ctl;
      samp_d.self_trig = line0[NUM_CRATE-1:0];
      samp_d.ctl       = line1[NUM_CRATE-1:0];
      samp_d.accept    = accept;
      samp_d.qual      = qual;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      samp_q     <= '0;
      ctl_prev_q <= '0;
    end else begin
      samp_q     <= samp_d;
      ctl_prev_q <= ctl_prev_d;
    end
  end

  // R12: captured values move only on a tick
  assert_capture_on_tick_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(samp_q));
endmodule

// File: rtl/frz_arm.sv
module frz_arm (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic line_now,
  input  logic line_prev,
  input  logic fire_cond,
  input  logic stop,
  output logic armed_q,
  output logic fire
);
  logic armed_d;
  logic set_edge;

  assign set_edge = line_now & ~line_prev;
  assign fire     = armed_q & fire_cond;

  always_comb begin
    armed_d = armed_q;
    if (tick) armed_d = ~stop & (set_edge | (armed_q & ~fire));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= armed_d;
  end

  // R9: a captured stop leaves the flag disarmed
  assert_stop_disarms_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tick && stop |=> !armed_q);
  // R8: a fire without a fresh edge leaves the flag disarmed
  assert_fire_disarms_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tick && fire && !set_edge |=> !armed_q);
endmodule

// File: rtl/frz_ctrl.sv
module frz_ctrl
  import frz_pkg::*;
#(
  parameter int NUM_CH = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bx_clk,
  input  logic [NUM_CH-1:0] req_line0,
  input  logic [NUM_CH-1:0] req_line1,
  input  logic              l1_accept,
  input  logic              collect_status,
  output logic              freeze_o
);
  logic rst_n_s;
  logic tick;
  samp_t samp_q;
  logic [NUM_CRATE-1:0] ctl_prev_q;
  logic [NUM_ARM-1:0] arm_q, fire, fire_cond;
  logic stop, any_self;
  logic freeze_q, freeze_d;
  logic unused_spare;

  frz_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .arst_n(rst_n), .rst_n_o(rst_n_s));

  frz_tick_gen u_tick (
    .clk(clk), .rst_n(rst_n_s), .bx_clk(bx_clk), .tick(tick));

  frz_sampler #(.NUM_CH(NUM_CH)) u_samp (
    .clk(clk), .rst_n(rst_n_s), .tick(tick),
    .line0(req_line0), .line1(req_line1),
    .accept(l1_accept), .qual(collect_status),
    .samp_q(samp_q), .ctl_prev_q(ctl_prev_q));

  assign stop     = samp_q.ctl[IDX_STOP];
  assign any_self = |samp_q.self_trig;

  assign fire_cond[IDX_ARM_ACC]  = samp_q.accept;
  assign fire_cond[IDX_ARM_QUAL] = samp_q.accept & samp_q.qual;

  for (genvar g = 0; g < NUM_ARM; g++) begin : g_arm
    frz_arm u_arm (
      .clk(clk), .rst_n(rst_n_s), .tick(tick),
      .line_now(samp_q.ctl[g]), .line_prev(ctl_prev_q[g]),
      .fire_cond(fire_cond[g]), .stop(stop),
      .armed_q(arm_q[g]), .fire(fire[g]));
  end

  assign unused_spare = ^{req_line0[NUM_CH-1:NUM_CRATE], req_line1[NUM_CH-1:NUM_CRATE],
                          samp_q.ctl[NUM_CRATE-1], ctl_prev_q[NUM_CRATE-1:IDX_STOP], arm_q};

  always_comb begin
    freeze_d = freeze_q;
    if (tick) begin
      if (stop) freeze_d = 1'b0;
      else      freeze_d = freeze_q | any_self | (|fire);
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) freeze_q <= 1'b0;
    else          freeze_q <= freeze_d;
  end

  assign freeze_o = freeze_q;

  // R12: output only moves after a tick
  assert_freeze_on_tick_R12: assert property (@(posedge clk) disable iff (!rst_n_s)
    !tick |=> $stable(freeze_q));
  // R7: stop beats any start
  assert_stop_wins_R7: assert property (@(posedge clk) disable iff (!rst_n_s)
    tick && stop |=> !freeze_q);
  // R6: held until stop
  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n_s)
    tick && freeze_q && !stop |=> freeze_q);
  // R2: self trigger sets the output
  assert_self_set_R2: assert property (@(posedge clk) disable iff (!rst_n_s)
    tick && any_self && !stop |=> freeze_q);
endmodule

// File: tb/frz_ctrl_tb_top.sv
module frz_ctrl_tb_top;
  localparam int NCH = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bx_clk = 1'b0;
  logic [NCH-1:0] req_line0 = '0;
  logic [NCH-1:0] req_line1 = '0;
  logic l1_accept = 1'b0;
  logic collect_status = 1'b0;
  logic freeze_o;

  int n_cmp = 0;
  int n_bad = 0;
  string cur_req = "R1";
  int ph = 0;

  always #4 clk = ~clk;

  frz_ctrl #(.NUM_CH(NCH)) dut_i (
    .clk(clk), .rst_n(rst_n), .bx_clk(bx_clk),
    .req_line0(req_line0), .req_line1(req_line1),
    .l1_accept(l1_accept), .collect_status(collect_status),
    .freeze_o(freeze_o));

  // slow clock: two fast cycles high, two low
  always @(negedge clk) begin
    ph <= (ph + 1) % 4;
    bx_clk <= ((ph + 1) % 4) < 2;
  end

  // behavioural reference model
  bit m_frz, m_arm_a, m_arm_q, m_bx_prev;
  bit [NCH-1:0] c0, c1, p1;
  bit c_l1, c_cs;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_frz = 0; m_arm_a = 0; m_arm_q = 0; c0 = '0; c1 = '0; p1 = '0;
      c_l1 = 0; c_cs = 0;
    end else if (bx_clk && !m_bx_prev) begin
      bit stp, fa, fq;
      stp = c1[2];
      fa  = m_arm_a && c_l1;
      fq  = m_arm_q && c_l1 && c_cs;
      m_frz   = stp ? 1'b0 : (m_frz || (|c0[3:0]) || fa || fq);
      m_arm_a = !stp && ((c1[0] && !p1[0]) || (m_arm_a && !fa));
      m_arm_q = !stp && ((c1[1] && !p1[1]) || (m_arm_q && !fq));
      p1 = c1; c0 = req_line0; c1 = req_line1; c_l1 = l1_accept; c_cs = collect_status;
    end
    m_bx_prev = bx_clk;
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      n_cmp++;
      if (freeze_o !== m_frz) begin
        n_bad++;
        $display("FAIL %s model compare: actual=%0b expected=%0b at %0t", cur_req, freeze_o, m_frz, $time);
      end
    end
  end

  task automatic chk(input string req, input bit exp);
    n_cmp++;
    if (freeze_o !== exp) begin
      n_bad++;
      $display("FAIL %s directed: actual=%0b expected=%0b at %0t", req, freeze_o, exp, $time);
    end
  endtask

  task automatic slow(input logic [NCH-1:0] r0, input logic [NCH-1:0] r1,
                      input logic l1, input logic cs);
    req_line0 = r0; req_line1 = r1; l1_accept = l1; collect_status = cs;
    repeat (4) @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) slow('0, '0, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    chk("R1", 1'b0);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    while (ph != 3) @(negedge clk);
    @(negedge clk);
    chk("R1", 1'b0);

    cur_req = "R2";
    for (int c = 0; c < 4; c++) begin
      slow(NCH'(1 << c), '0, 0, 0);
      chk("R12", 1'b0);             // not yet: next tick updates
      idle(1); chk("R2", 1'b1);
      cur_req = "R6"; idle(2); slow('0, '0, 1, 1); idle(1); chk("R6", 1'b1);
      slow('0, 5'b00100, 0, 0); idle(1); chk("R6", 1'b0);
      cur_req = "R2";
    end

    cur_req = "R3";
    slow(5'b10000, 5'b10000, 0, 0); idle(2); chk("R3", 1'b0);
    slow('0, 5'b10000, 0, 0); idle(1); slow('0, '0, 1, 1); idle(1); chk("R3", 1'b0);

    cur_req = "R4";
    slow('0, '0, 1, 0); idle(1); chk("R4", 1'b0);
    slow('0, 5'b00001, 0, 0); idle(1); slow('0, '0, 1, 0); idle(1); chk("R4", 1'b1);
    slow('0, 5'b00100, 0, 0); idle(1); chk("R6", 1'b0);

    cur_req = "R8";
    slow('0, '0, 1, 0); idle(1); chk("R8", 1'b0);

    cur_req = "R5";
    slow('0, 5'b00010, 0, 0); idle(1);
    slow('0, '0, 1, 0); idle(1); chk("R5", 1'b0);
    slow('0, '0, 0, 1); idle(1); chk("R5", 1'b0);
    slow('0, '0, 1, 1); idle(1); chk("R5", 1'b1);
    slow('0, 5'b00100, 0, 0); idle(1); chk("R6", 1'b0);
    slow('0, '0, 1, 1); idle(1); chk("R8", 1'b0);

    cur_req = "R9";
    slow('0, 5'b00011, 0, 0); idle(1);
    slow('0, 5'b00100, 0, 0); idle(1);
    slow('0, '0, 1, 1); idle(1); chk("R9", 1'b0);

    cur_req = "R7";
    slow(5'b00001, 5'b00100, 0, 0); idle(1); chk("R7", 1'b0);
    slow(5'b00010, '0, 0, 0); idle(1); chk("R2", 1'b1);
    slow(5'b01000, 5'b00100, 0, 0); idle(1); chk("R7", 1'b0);

    cur_req = "R10";
    slow('0, 5'b00001, 0, 0); slow('0, 5'b00001, 0, 0);
    slow('0, 5'b00001, 1, 0); slow('0, 5'b00001, 0, 0); chk("R10", 1'b1);
    slow('0, 5'b00101, 0, 0); slow('0, 5'b00001, 0, 0); chk("R10", 1'b0);
    slow('0, 5'b00001, 1, 0); slow('0, 5'b00001, 0, 0); chk("R10", 1'b0);
    idle(2);

    cur_req = "R11";
    slow('0, 5'b01000, 0, 0); idle(1); slow('0, '0, 1, 1); idle(1); chk("R11", 1'b0);
    slow(5'b00100, '0, 0, 0); slow('0, 5'b01000, 0, 0); idle(1); chk("R11", 1'b1);
    slow('0, 5'b00100, 0, 0); idle(2); chk("R11", 1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(negedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule